// File: doc/BRIEF.md
# Run-Mode Clock Source Switch Controller

This block chooses which oscillator drives the CPU and peripheral clock of a small microcontroller. It chooses between a primary external oscillator and an internal RC oscillator. A 2-bit select field names the wanted source. The value 2'b11 picks the internal RC oscillator, and every other value asks for the primary oscillator.

When the primary oscillator is requested, the block turns the primary oscillator on and keeps the system running on the RC clock. A start-up timer in the primary domain then counts 1024 primary periods. Only after that count does a glitch-free multiplexer hand the system clock over, and a status flag is then raised. On the way back, the status flag drops as soon as the RC clock drives the output again, and the primary oscillator is then turned off.

The RC oscillator may stop while the primary clock runs. It is kept running whenever the watchdog enable or the fail-safe monitor enable is set.

Top module: `clk_src_switch`

## Requirements
- R1: After reset the system clock comes from the RC oscillator, the status flag is 0, the primary enable is 0 and the RC enable is 1.
- R2: While the select field holds 2'b11, the system clock period equals the RC period and, once settled, the primary enable is 0.
- R3: Returning to 2'b11 from an active primary clock clears the status flag once the RC clock again drives the output, and the status flag is never 1 while the primary enable is 0.
- R4: A select value other than 2'b11 asserts the primary enable. During the start-up interval, the system clock stays on the RC oscillator and the status flag stays 0 for at least 1024 primary periods.
- R5: After 1024 primary periods have been counted, the system clock switches to the primary oscillator and the status flag becomes 1, only once the primary gate drives the output.
- R6: The system clock never carries a pulse or gap shorter than half a period of the faster input clock, and the two source gates are never both open.
- R7: The RC enable is 1 whenever the watchdog enable or the fail-safe enable is 1. With both at 0 and the primary clock active under a primary select value, the RC enable is 0.
- R8: If the select field goes back to 2'b11 before the count ends, no switch happens, the primary enable drops and the count restarts. A later request then waits the full 1024 periods again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_rc_i | input | 1 | Internal RC oscillator clock |
| clk_pri_i | input | 1 | Primary oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_sel_i | input | 2 | Source select; 2'b11 = RC, other values = primary |
| wdt_en_i | input | 1 | Watchdog enable, keeps the RC oscillator alive |
| fscm_en_i | input | 1 | Fail-safe monitor enable, keeps the RC oscillator alive |
| sys_clk_o | output | 1 | CPU and peripheral clock |
| pri_osc_en_o | output | 1 | Primary oscillator run enable |
| rc_osc_en_o | output | 1 | RC oscillator run enable |
| ost_done_o | output | 1 | Status: 1 while the primary clock drives the system |

## Verification
A controller state that is wrong shows at once as the wrong period on the system clock or a wrong oscillator enable. A start-up count that ends early raises the status flag before 1024 primary periods have passed since the request, and a count that is not restarted does the same after an abandoned request. A fault in the gate handshake shows as a short pulse on the system clock within a few cycles of the switch. If the RC oscillator is wrongly stopped, the controller freezes, which shows as a missing return to the RC period.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  typedef enum logic [2:0] {
    ST_RC     = 3'd0,
    ST_WAIT   = 3'd1,
    ST_TO_PRI = 3'd2,
    ST_PRI    = 3'd3,
    ST_TO_RC  = 3'd4
  } clksw_state_e;

  localparam logic [1:0] SEL_RC_CODE = 2'b11;
endpackage

// File: rtl/clksw_sync.sv
module clksw_sync #(
  parameter int           WIDTH   = 1,
  parameter int           STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_n [STAGES];

  always_comb begin
    stg_n[0] = d_i;
    for (int i = 1; i < STAGES; i++) stg_n[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_n[i];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/clksw_ost.sv
module clksw_ost #(
  parameter int CYCLES = 1024
) (
  input  logic clk_pri,
  input  logic rst_n,
  output logic done_o
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             done_q, done_n;
  logic             cnt_en;

  always_comb begin
    cnt_en = ~done_q;
    cnt_n  = cnt_q;
    done_n = done_q;
    if (cnt_en) begin
      cnt_n = cnt_q + CNT_W'(1);
      if (cnt_q == LAST) done_n = 1'b1;
    end
  end

  always_ff @(posedge clk_pri or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      done_q <= done_n;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/clksw_gate_cell.sv
module clksw_gate_cell #(
  parameter int   STAGES = 2,
  parameter logic RST_ON = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic gate_o
);
  logic req_s;
  logic gate_q;

  clksw_sync #(.WIDTH(1), .STAGES(STAGES), .RST_VAL(RST_ON)) u_req_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (req_i),
    .q_o   (req_s)
  );

  // gate updates while the clock is low, so the AND never chops a pulse
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= RST_ON;
    else        gate_q <= req_s;
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch
  import clksw_pkg::*;
#(
  parameter int OST_CYCLES  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_rc_i,
  input  logic       clk_pri_i,
  input  logic       rst_ni,
  input  logic [1:0] clk_sel_i,
  input  logic       wdt_en_i,
  input  logic       fscm_en_i,
  output logic       sys_clk_o,
  output logic       pri_osc_en_o,
  output logic       rc_osc_en_o,
  output logic       ost_done_o
);
  logic rc_rst_n;
  logic pri_rst_n;
  logic pri_arst_n;
  logic req_pri_raw;
  logic req_pri_s;
  logic ost_ready_pri;
  logic ost_ready_rc;
  logic gate_rc;
  logic gate_pri;
  logic gate_pri_rc;

  clksw_state_e state_q, state_n;
  logic         sel_pri_q, sel_pri_n;
  logic         pri_en_q, pri_en_n;
  logic         status_q, status_n;

  // reset synchronizers
  clksw_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rc_rst (
    .clk (clk_rc_i), .rst_n (rst_ni), .d_i (1'b1), .q_o (rc_rst_n)
  );

  assign pri_arst_n = rst_ni & pri_en_q;

  clksw_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pri_rst (
    .clk (clk_pri_i), .rst_n (pri_arst_n), .d_i (1'b1), .q_o (pri_rst_n)
  );

  // select request into the RC domain
  assign req_pri_raw = (clk_sel_i != SEL_RC_CODE);

  clksw_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
    .clk (clk_rc_i), .rst_n (rc_rst_n), .d_i (req_pri_raw), .q_o (req_pri_s)
  );

  // start-up timer in the primary domain
  clksw_ost #(.CYCLES(OST_CYCLES)) u_ost (
    .clk_pri (clk_pri_i),
    .rst_n   (pri_rst_n),
    .done_o  (ost_ready_pri)
  );

  clksw_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ready_sync (
    .clk (clk_rc_i), .rst_n (rc_rst_n), .d_i (ost_ready_pri), .q_o (ost_ready_rc)
  );

  // glitch-free gate pair with cross feedback
  clksw_gate_cell #(.STAGES(SYNC_STAGES), .RST_ON(1'b1)) u_gate_rc (
    .clk    (clk_rc_i),
    .rst_n  (rc_rst_n),
    .req_i  (~sel_pri_q & ~gate_pri),
    .gate_o (gate_rc)
  );

  clksw_gate_cell #(.STAGES(SYNC_STAGES), .RST_ON(1'b0)) u_gate_pri (
    .clk    (clk_pri_i),
    .rst_n  (pri_rst_n),
    .req_i  (sel_pri_q & ~gate_rc),
    .gate_o (gate_pri)
  );

  clksw_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_gpri_sync (
    .clk (clk_rc_i), .rst_n (rc_rst_n), .d_i (gate_pri), .q_o (gate_pri_rc)
  );

  // switch controller, RC domain
  always_comb begin
    state_n   = state_q;
    sel_pri_n = sel_pri_q;
    pri_en_n  = pri_en_q;
    status_n  = status_q;
    unique case (state_q)
      ST_RC: begin
        pri_en_n = 1'b0;
        if (req_pri_s && !ost_ready_rc) begin
          state_n  = ST_WAIT;
          pri_en_n = 1'b1;
        end
      end
      ST_WAIT: begin
        if (!req_pri_s) begin
          state_n  = ST_RC;
          pri_en_n = 1'b0;
        end else if (ost_ready_rc) begin
          state_n   = ST_TO_PRI;
          sel_pri_n = 1'b1;
        end
      end
      ST_TO_PRI: begin
        if (gate_pri_rc) begin
          state_n  = ST_PRI;
          status_n = 1'b1;
        end
      end
      ST_PRI: begin
        if (!req_pri_s) begin
          state_n   = ST_TO_RC;
          sel_pri_n = 1'b0;
        end
      end
      ST_TO_RC: begin
        if (gate_rc) begin
          state_n  = ST_RC;
          status_n = 1'b0;
          pri_en_n = 1'b0;
        end
      end
      default: begin
        state_n   = ST_RC;
        sel_pri_n = 1'b0;
        pri_en_n  = 1'b0;
        status_n  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_rc_i or negedge rc_rst_n) begin
    if (!rc_rst_n) begin
      state_q   <= ST_RC;
      sel_pri_q <= 1'b0;
      pri_en_q  <= 1'b0;
      status_q  <= 1'b0;
    end else begin
      state_q   <= state_n;
      sel_pri_q <= sel_pri_n;
      pri_en_q  <= pri_en_n;
      status_q  <= status_n;
    end
  end

  // outputs
  assign sys_clk_o    = (clk_rc_i & gate_rc) | (clk_pri_i & gate_pri);
  assign pri_osc_en_o = pri_en_q;
  assign ost_done_o   = status_q;
  assign rc_osc_en_o  = wdt_en_i | fscm_en_i |
                        ~((state_q == ST_PRI) & req_pri_raw);
endmodule

// File: rtl/clk_src_switch_chk.sv
module clk_src_switch_chk (
  input logic clk_rc,
  input logic clk_pri,
  input logic rst_n,
  input logic gate_rc,
  input logic gate_pri,
  input logic status,
  input logic pri_en,
  input logic ost_ready_pri
);
  always_comb begin
    if (rst_n) begin
      a_r6_gates_exclusive: assert (!(gate_rc && gate_pri));
    end
  end

  a_r3_status_needs_pri_en: assert property (
    @(posedge clk_rc) disable iff (!rst_n) status |-> pri_en);

  a_r5_status_rise_on_pri_gate: assert property (
    @(posedge clk_rc) disable iff (!rst_n) $rose(status) |-> gate_pri);

  a_r3_status_fall_on_rc_gate: assert property (
    @(posedge clk_rc) disable iff (!rst_n) $fell(status) |-> gate_rc);

  a_r4_pri_gate_after_count: assert property (
    @(posedge clk_pri) disable iff (!rst_n) gate_pri |-> ost_ready_pri);
endmodule

bind clk_src_switch clk_src_switch_chk u_chk (
  .clk_rc        (clk_rc_i),
  .clk_pri       (clk_pri_i),
  .rst_n         (rst_ni),
  .gate_rc       (gate_rc),
  .gate_pri      (gate_pri),
  .status        (status_q),
  .pri_en        (pri_en_q),
  .ost_ready_pri (ost_ready_pri)
);

// File: tb/clk_src_switch_bench.sv
`timescale 1ns/1ps
module clk_src_switch_bench;
  logic       clk_rc, clk_pri, ref_clk;
  logic       rst_ni;
  logic [1:0] clk_sel;
  logic       wdt_en, fscm_en;
  logic       sys_clk, pri_en, rc_en, status;

  int n_checks = 0;
  int n_fail   = 0;
  int wd_cnt   = 0;
  int glitch_cnt = 0;
  realtime last_edge = 0.0;

  clk_src_switch u_clk_src_switch (
    .clk_rc_i     (clk_rc),
    .clk_pri_i    (clk_pri),
    .rst_ni       (rst_ni),
    .clk_sel_i    (clk_sel),
    .wdt_en_i     (wdt_en),
    .fscm_en_i    (fscm_en),
    .sys_clk_o    (sys_clk),
    .pri_osc_en_o (pri_en),
    .rc_osc_en_o  (rc_en),
    .ost_done_o   (status)
  );

  // 250 MHz reference, edges on odd ns (never coincide with oscillator edges)
  initial begin
    ref_clk = 1'b0;
    #1;
    forever #2 ref_clk = ~ref_clk;
  end

  // RC oscillator model: 4 ns period, halts low while disabled
  initial begin
    clk_rc = 1'b0;
    forever begin
      #2;
      if (rc_en !== 1'b0 || clk_rc) clk_rc = ~clk_rc;
    end
  end

  // primary oscillator model: 3 ns period, halts low while disabled
  initial begin
    clk_pri = 1'b0;
    #0.25;
    forever begin
      #1.5;
      if (pri_en === 1'b1 || clk_pri) clk_pri = ~clk_pri;
    end
  end

  // R6 monitor: minimum pulse/gap on the system clock
  always @(sys_clk) begin
    if (rst_ni === 1'b1 && ($realtime - last_edge) < 1.4) glitch_cnt++;
    last_edge = $realtime;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
  endtask

  always @(posedge ref_clk) begin
    wd_cnt++;
    if (wd_cnt > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", wd_cnt);
      summary();
      $finish;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_ref(input int n);
    repeat (n) @(posedge ref_clk);
  endtask

  // system clock period in units of 0.1 ns
  task automatic measure(output int per);
    realtime t0, t1;
    @(posedge sys_clk);
    t0 = $realtime;
    @(posedge sys_clk);
    t1 = $realtime;
    per = int'((t1 - t0) * 10.0);
    @(posedge ref_clk);
  endtask

  function automatic int exp_pri(input logic [1:0] s);
    return (s != 2'b11) ? 1 : 0;
  endfunction

  function automatic int exp_rc_en(input logic [1:0] s, input logic w, input logic f);
    return (w || f || s == 2'b11) ? 1 : 0;
  endfunction

  function automatic int exp_period(input logic [1:0] s);
    return (s == 2'b11) ? 40 : 30;
  endfunction

  initial begin
    int per;
    void'($urandom(32'd20240611));
    rst_ni  = 1'b0;
    clk_sel = 2'b11;
    wdt_en  = 1'b0;
    fscm_en = 1'b0;
    wait_ref(5);
    check("R1", "status in reset", int'(status), 0);
    check("R1", "pri_en in reset", int'(pri_en), 0);
    check("R1", "rc_en in reset", int'(rc_en), 1);
    rst_ni = 1'b1;
    wait_ref(20);
    measure(per);
    check("R1", "period after reset", per, 40);
    check("R2", "pri_en on rc select", int'(pri_en), 0);

    // request primary: start-up interval on RC
    clk_sel = 2'b00;
    wait_ref(250);
    check("R4", "pri_en during start-up", int'(pri_en), 1);
    check("R4", "status during start-up", int'(status), 0);
    measure(per);
    check("R4", "period during start-up", per, 40);
    wait_ref(499);
    check("R4", "status before 1024 periods", int'(status), 0);
    wait_ref(200);
    check("R5", "status after switch", int'(status), 1);
    measure(per);
    check("R5", "period on primary", per, 30);
    check("R7", "rc_en with no keep-alive", int'(rc_en), 0);

    wdt_en = 1'b1;
    wait_ref(10);
    check("R7", "rc_en with watchdog", int'(rc_en), 1);
    wdt_en = 1'b0; fscm_en = 1'b1;
    wait_ref(10);
    check("R7", "rc_en with fail-safe", int'(rc_en), 1);
    fscm_en = 1'b0;
    wait_ref(10);
    check("R7", "rc_en released", int'(rc_en), 0);

    // back to RC
    clk_sel = 2'b11;
    wait_ref(100);
    check("R3", "status after return", int'(status), 0);
    check("R2", "pri_en after return", int'(pri_en), 0);
    measure(per);
    check("R2", "period after return", per, 40);

    // abandoned start-up, then a fresh full count
    clk_sel = 2'b10;
    wait_ref(250);
    check("R8", "pri_en before abandon", int'(pri_en), 1);
    clk_sel = 2'b11;
    wait_ref(50);
    check("R8", "pri_en after abandon", int'(pri_en), 0);
    check("R8", "status after abandon", int'(status), 0);
    measure(per);
    check("R8", "period after abandon", per, 40);
    clk_sel = 2'b01;
    wait_ref(700);
    check("R8", "status mid restart", int'(status), 0);
    wait_ref(250);
    check("R8", "status after restart", int'(status), 1);
    clk_sel = 2'b11;
    wait_ref(100);

    // constrained random
    for (int it = 0; it < 16; it++) begin
      clk_sel = 2'($urandom % 4);
      wdt_en  = (($urandom % 4) == 0);
      fscm_en = (($urandom % 4) == 0);
      wait_ref(1000);
      check("R5", "random status", int'(status), exp_pri(clk_sel));
      check("R4", "random pri_en", int'(pri_en), exp_pri(clk_sel));
      check("R7", "random rc_en", int'(rc_en), exp_rc_en(clk_sel, wdt_en, fscm_en));
      measure(per);
      check("R2", "random period", per, exp_period(clk_sel));
    end

    check("R6", "short pulses on system clock", glitch_cnt, 0);
    summary();
    $finish;
  end
endmodule